// File: doc/BRIEF.md
# Hybrid Cache Fill and Victim Selector

This block makes the placement decision for one miss in a 16-way shared last-level cache. The cache has two kinds of data storage. A small region, ways 0 to 3, is cheap to write. A larger region, ways 4 to 15, is cheap to read but costly to write.

For each miss the block receives the following:
- the requesting core;
- whether the miss came from a store or from a load;
- the valid bit, 2-bit owner and 4-bit recency rank of every way in the indexed set;
- the number of ways the partitioning logic currently grants to that core.

It answers one cycle later with the region to fill and the way to evict. The choice counts how many blocks the core already holds in each region of the set and compares those counts with the core's quota. A core can therefore hold extra write-efficient ways and shrink its share of the read-efficient region, or take ways there from other cores.

An optional switching mode swaps the load and store treatment for a small, fixed fraction of misses. It uses a pseudo-random sequence, so that a core whose misses are almost all of one kind still spreads its blocks into both regions. The tag and data arrays, block migration and the calculation of quotas belong to other blocks.

Top module: `hybrid_fill_selector`

## Requirements
- R1: After reset `rsp_valid` is 0, and `req_ready` is 0 during reset and 1 from the first clock edge after it. Each accepted request (`req_valid` and `req_ready` both high at a rising edge) produces exactly one response with `rsp_valid`=1 in the following cycle. Without an accepted request, `rsp_valid` is 0.
- R2: `rsp_fast`=1 names the write-efficient region, and the way is then in 0..3. `rsp_fast`=0 names the read-efficient region, and the way is then in 4..15.
- R3: A store miss always fills the write-efficient region. Let "own" mean valid ways whose 2-bit owner equals the requesting core, and let S be the core's own count in ways 0..3. If S is at least the quota, the victim is the least-recent of the core's own ways in 0..3. Otherwise the victim is the least-recent of all ways in 0..3.
- R4: A load miss with S at least the quota is handled exactly like a store miss.
- R5: A load miss with S below the quota fills ways 4..15. Let M be the core's own count in 4..15. If M is at least (quota − S), the victim is the least-recent of the core's own ways there. Otherwise it is the least-recent of the valid ways there owned by other cores.
- R6: A load miss from a core that owns no ways in 4..15 (and has S below quota) takes its victim from another core's ways in that region.
- R7: When S exceeds a quota that has shrunk, including a quota of 0, both miss kinds keep filling ways 0..3 by evicting the core's own blocks there.
- R8: If the chosen region has an invalid way, the lowest-numbered invalid way of that region is returned before any eviction. Invalid ways in the other region do not matter.
- R9: Recency rank 15 is least recent, and the highest rank in the candidate group wins, with the lowest way index breaking ties. If the candidate group is empty, the least-recent way of the whole chosen region is used.
- R10: With `switch_en`=1, a 16-bit state register (seed 0xACE1) steps once per accepted request as s ← {s[14:0], s[15]^s[13]^s[12]^s[10]}, whatever `switch_en` is. When the value before the step is below 1311, the miss kind is inverted (load treated as store and the reverse) and `rsp_switched` is 1.
- R11: With `switch_en`=0, no miss is switched and `rsp_switched` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Block accepts a request |
| req_core | input | 2 | Requesting core |
| req_is_store | input | 1 | 1 = store-caused miss, 0 = load-caused miss |
| switch_en | input | 1 | Enables pseudo-random swapping of the miss kind |
| quota | input | 5 | Ways granted to the core by partitioning (0..16) |
| way_valid | input | 16 | Valid bit per way |
| way_owner | input | 32 | Owner per way, way i at bits [2i+1:2i] |
| way_rank | input | 64 | Recency rank per way, way i at bits [4i+3:4i], 15 = least recent |
| rsp_valid | output | 1 | Decision present |
| rsp_fast | output | 1 | 1 = fill in ways 0..3, 0 = fill in ways 4..15 |
| rsp_way | output | 4 | Victim way |
| rsp_switched | output | 1 | Miss kind was inverted for this decision |

## Verification
A table of set snapshots exercises each branch of the decision. Each snapshot pairs a recency order with an ownership pattern chosen so that the correct candidate group and a wrong one (own versus shared, own versus other cores) point to different ways. Separate rows cover the following cases:
- an invalid way in the chosen region, and one in the other region;
- a quota of 0 and a quota of 16;
- a core that owns nothing;
- all ranks equal.

A long run with switching enabled alternates loads and stores. Its expected sequence comes from the stated register recurrence, which shows whether the switch decision and its effect on region and way follow each step.

// File: rtl/hybrid_fill_selector.sv
module hybrid_fill_selector #(
  parameter int          NUM_WAYS     = 16,
  parameter int          FAST_WAYS    = 4,
  parameter int          CORE_W       = 2,
  parameter int          RANK_W       = 4,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1,
  parameter int          SWITCH_LIMIT = 1311
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [CORE_W-1:0]          req_core,
  input  logic                       req_is_store,
  input  logic                       switch_en,
  input  logic [$clog2(NUM_WAYS+1)-1:0] quota,
  input  logic [NUM_WAYS-1:0]        way_valid,
  input  logic [NUM_WAYS*CORE_W-1:0] way_owner,
  input  logic [NUM_WAYS*RANK_W-1:0] way_rank,
  output logic                       rsp_valid,
  output logic                       rsp_fast,
  output logic [$clog2(NUM_WAYS)-1:0] rsp_way,
  output logic                       rsp_switched
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int CNT_W = $clog2(NUM_WAYS+1);

  logic [NUM_WAYS-1:0] own, fast_m, region, group, hole, cand;
  logic [CNT_W-1:0]    ns, nm, room;
  logic [15:0]         lfsr;
  logic                accept, switch_hit, eff_store, use_fast;
  logic [WAY_W-1:0]    pick;

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_way
    assign own[i]    = way_valid[i] && (way_owner[i*CORE_W +: CORE_W] == req_core);
    assign fast_m[i] = (i < FAST_WAYS);
  end

  assign accept     = req_valid && req_ready;
  assign ns         = CNT_W'($countones(own & fast_m));
  assign nm         = CNT_W'($countones(own & ~fast_m));
  assign switch_hit = switch_en && (lfsr < 16'(SWITCH_LIMIT));
  assign eff_store  = req_is_store ^ switch_hit;
  assign use_fast   = eff_store || (ns >= quota);
  assign room       = quota - ns;
  assign region     = use_fast ? fast_m : ~fast_m;
  assign hole       = region & ~way_valid;

  always_comb begin
    if (use_fast)        group = (ns >= quota) ? (own & fast_m) : fast_m;
    else if (nm >= room) group = own & ~fast_m;
    else                 group = way_valid & ~own & ~fast_m;
    cand = (|group) ? group : region;
  end

  always_comb begin
    logic             found;
    logic [RANK_W-1:0] best;
    pick  = '0;
    found = 1'b0;
    best  = '0;
    if (|hole) begin
      for (int i = 0; i < NUM_WAYS; i++)
        if (hole[i] && !found) begin
          pick  = WAY_W'(i);
          found = 1'b1;
        end
    end else begin
      for (int i = 0; i < NUM_WAYS; i++)
        if (cand[i] && (!found || way_rank[i*RANK_W +: RANK_W] > best)) begin
          pick  = WAY_W'(i);
          best  = way_rank[i*RANK_W +: RANK_W];
          found = 1'b1;
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready    <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_fast     <= 1'b0;
      rsp_way      <= '0;
      rsp_switched <= 1'b0;
      lfsr         <= LFSR_SEED;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accept;
      if (accept) begin
        rsp_fast     <= use_fast;
        rsp_way      <= pick;
        rsp_switched <= switch_hit;
        lfsr         <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
    end
  end

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid); // R1
  AST_WAY_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fast == (rsp_way < WAY_W'(FAST_WAYS)))); // R2
  AST_STORE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_is_store && !switch_en) |=> rsp_fast); // R3
  AST_OVER_QUOTA_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ns >= quota) |=> rsp_fast); // R4
  AST_SWITCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !switch_en) |=> !rsp_switched); // R11
  AST_SWITCH_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lfsr >= 16'(SWITCH_LIMIT)) |=> !rsp_switched); // R10
endmodule

// File: tb/hybrid_fill_selector_bench.sv
module hybrid_fill_selector_bench;
  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  core;
    logic        st;
    logic [4:0]  quota;
    logic [15:0] valid;
    logic [31:0] owner;
    logic [63:0] rank;
    logic        fast;
    logic [3:0]  way;
  } vec_t;

  localparam logic [63:0] RA = 64'h0123456789ABCDEF; // way i rank 15-i
  localparam logic [63:0] RB = 64'hFEDCBA9876543210; // way i rank i
  localparam logic [31:0] OM = 32'hE4E4E4E4;         // owner of way i = i mod 4

  localparam vec_t VECS [14] = '{
    '{4'd3, 2'd1, 1'b1, 5'd8,  16'hFFFF, OM,           RA,    1'b1, 4'd0},  // R3 shared pick
    '{4'd3, 2'd1, 1'b1, 5'd1,  16'hFFFF, OM,           RA,    1'b1, 4'd1},  // R3 own pick
    '{4'd4, 2'd1, 1'b0, 5'd1,  16'hFFFF, OM,           RB,    1'b1, 4'd1},  // R4
    '{4'd5, 2'd1, 1'b0, 5'd3,  16'hFFFF, OM,           RB,    1'b0, 4'd13}, // R5 own slow
    '{4'd5, 2'd1, 1'b0, 5'd8,  16'hFFFF, OM,           RA,    1'b0, 4'd4},  // R5 others slow
    '{4'd6, 2'd3, 1'b0, 5'd4,  16'hFFFF, 32'h00000000, RB,    1'b0, 4'd15}, // R6
    '{4'd8, 2'd0, 1'b1, 5'd2,  16'hFFF7, 32'h00000000, RA,    1'b1, 4'd3},  // R8
    '{4'd8, 2'd1, 1'b0, 5'd8,  16'hFBFF, OM,           RA,    1'b0, 4'd10}, // R8
    '{4'd8, 2'd1, 1'b1, 5'd8,  16'hFBFF, OM,           RA,    1'b1, 4'd0},  // R8 other region hole
    '{4'd7, 2'd0, 1'b0, 5'd2,  16'hFFFF, 32'h00000000, RA,    1'b1, 4'd0},  // R7
    '{4'd7, 2'd0, 1'b1, 5'd0,  16'hFFFF, OM,           RB,    1'b1, 4'd0},  // R7 quota zero
    '{4'd9, 2'd3, 1'b1, 5'd0,  16'hFFFF, 32'h55555555, RB,    1'b1, 4'd3},  // R9 fallback
    '{4'd9, 2'd1, 1'b0, 5'd8,  16'hFFFF, OM,           64'h0, 1'b0, 4'd4},  // R9 tie
    '{4'd5, 2'd1, 1'b0, 5'd16, 16'hFFFF, 32'h55555555, RB,    1'b0, 4'd15}  // R5 full quota
  };

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_is_store = 0, switch_en = 0;
  logic [1:0]  req_core = 0;
  logic [4:0]  quota = 0;
  logic [15:0] way_valid = 0;
  logic [31:0] way_owner = 0;
  logic [63:0] way_rank = 0;
  logic        req_ready, rsp_valid, rsp_fast, rsp_switched;
  logic [3:0]  rsp_way;
  logic [15:0] model_lfsr = 16'hACE1;
  int checks = 0, failures = 0, switches = 0;

  always #2.5 clk = ~clk;

  hybrid_fill_selector u_hybrid_fill_selector (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_is_store(req_is_store), .switch_en(switch_en),
    .quota(quota), .way_valid(way_valid), .way_owner(way_owner), .way_rank(way_rank),
    .rsp_valid(rsp_valid), .rsp_fast(rsp_fast), .rsp_way(rsp_way), .rsp_switched(rsp_switched));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic s, input logic [4:0] q,
                       input logic [15:0] v, input logic [31:0] o, input logic [63:0] r);
    @(negedge clk);
    req_core = c; req_is_store = s; quota = q; way_valid = v; way_owner = o; way_rank = r;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    model_lfsr = {model_lfsr[14:0], model_lfsr[15] ^ model_lfsr[13] ^ model_lfsr[12] ^ model_lfsr[10]};
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired R1 actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #12;
    check(rsp_valid == 0, "R1 reset rsp_valid", rsp_valid, 0);
    check(req_ready == 0, "R1 reset req_ready", req_ready, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid == 0, "R1 idle no response", rsp_valid, 0);

    foreach (VECS[k]) begin
      vec_t t = VECS[k];
      issue(t.core, t.st, t.quota, t.valid, t.owner, t.rank);
      check(rsp_valid == 1, $sformatf("R1 row %0d response", k), rsp_valid, 1);
      check(rsp_fast == t.fast, $sformatf("R%0d row %0d region", t.rq, k), rsp_fast, t.fast);
      check(rsp_way == t.way, $sformatf("R%0d row %0d way", t.rq, k), rsp_way, t.way);
      check(rsp_switched == 0, $sformatf("R11 row %0d switch", k), rsp_switched, 0);
      check((rsp_way < 4) == rsp_fast, $sformatf("R2 row %0d way in region", k), rsp_way, t.way);
    end
    @(negedge clk);
    check(rsp_valid == 0, "R1 single response", rsp_valid, 0);

    switch_en = 1;
    for (int i = 0; i < 2000; i++) begin
      logic sw, eff;
      sw  = model_lfsr < 16'd1311;
      eff = i[0] ^ sw;
      if (sw) switches++;
      issue(2'd1, i[0], 5'd8, 16'hFFFF, OM, RA);
      check(rsp_switched == sw, "R10 switch flag", rsp_switched, sw);
      check(rsp_fast == eff, "R10 switched region", rsp_fast, eff);
      check(rsp_way == (eff ? 4'd0 : 4'd4), "R10 switched way", rsp_way, eff ? 0 : 4);
    end
    check(switches > 0, "R10 some switches seen", switches, 1);
    check(switches < 200, "R10 switch rate small", switches, 40);

    switch_en = 0;
    issue(2'd1, 1'b0, 5'd8, 16'hFFFF, OM, RA);
    check(rsp_switched == 0 && rsp_fast == 0, "R11 disabled after run", rsp_fast, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule